// File: doc/BRIEF.md
# Edge-Timestamp PS/2 Frame Receiver

This block receives device-to-host PS/2 frames without sampling the data line at each clock fall. When the idle data line drops for the start bit, a timestamp counter restarts and the receiver records the time of every later data-line change. The eleventh falling edge of the PS/2 clock closes the frame and records its duration.

The bit period is derived from that duration. Each recorded data change is then placed on its nearest bit boundary, and the eleven bit levels are rebuilt from those placements. The result is a byte, a one-cycle valid strobe, and parity and framing flags. The inputs are expected to be already synchronised to the system clock.

A stalled partial frame is discarded after a programmable silence on the PS/2 clock. Because of this, a later frame always starts from a clean state.

Top module: `ps2_edge_rx`

## Requirements
- R1: Out of reset, `rx_valid_o`, `rx_byte_o`, `parity_err_o` and `frame_err_o` are all zero.
- R2: A frame is a low start bit, eight data bits sent least significant first, one parity bit and a high stop bit. The data line changes at bit boundaries and the clock falls mid-bit. `rx_byte_o` returns the eight data bits. `rx_valid_o` rises on the 12th system clock edge after the edge that first samples the eleventh PS/2 clock fall of the frame.
- R3: `rx_valid_o` is high for exactly one system clock cycle per frame.
- R4: `rx_byte_o`, `parity_err_o` and `frame_err_o` hold their values from one valid strobe until the next, including while a new frame is being received.
- R5: Parity is odd. `parity_err_o` is 1 when the number of ones across the eight data bits and the parity bit is even, and 0 otherwise.
- R6: `frame_err_o` is 1 when the rebuilt start bit is high or the rebuilt stop bit is low.
- R7: Frames decode correctly for any even bit period from 20 to 100 system clocks, and the period may differ from one frame to the next.
- R8: Frames with the densest data toggling decode correctly. This includes alternating patterns such as 0xAA and 0x55 with up to ten stored transitions.
- R9: If a frame is in progress and no PS/2 clock fall arrives for `IDLE_CYCLES` system clocks, the partial frame is dropped without a valid strobe. The next complete frame then decodes correctly.
- R10: A data change anywhere within a quarter bit period of its nominal boundary decodes to the same byte.
- R11: PS/2 clock activity while the data line stays high and no frame is open produces no valid strobe and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Synchronised PS/2 clock line |
| ps2_dat_i | input | 1 | Synchronised PS/2 data line |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe when a frame has been decoded |
| parity_err_o | output | 1 | Odd-parity check failed on the last frame |
| frame_err_o | output | 1 | Start or stop bit wrong on the last frame |

## Verification
Edge detection is combinational on the inputs, so a line change driven between clock edges is seen at the next rising edge. That edge captures the timestamp. The eleven decode steps and the output register follow it, and the strobe appears twelve edges later.

The bench drives every line change at a falling clock edge. After the last PS/2 clock fall it counts exactly twelve rising edges and checks at the following falling edge that the strobe is still low. One edge later it checks that the strobe is high and that the byte and both flags are correct, and on the next cycle that the strobe has dropped again.

The outputs are also sampled just before each frame's final clock fall to confirm they still hold the previous result. The timeout case holds the lines idle for longer than the window, checks that no strobe appeared, and then sends a full frame.

// File: rtl/ps2ts_pkg.sv
`timescale 1ns/1ps
package ps2ts_pkg;
    // Frame length in bits: start, eight data, parity, stop.
    localparam int FRAME_BITS = 11;
    // Index of the PS/2 clock fall that closes a frame (counted from 0).
    localparam int LAST_FALL  = FRAME_BITS - 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_DECODE = 2'd2,
        ST_FINISH = 2'd3
    } rx_state_e;
endpackage

// File: rtl/ps2ts_line_edges.sv
`timescale 1ns/1ps
module ps2ts_line_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic clk_fall_o,
    output logic dat_fall_o,
    output logic dat_edge_o
);
    typedef struct packed {
        logic clk_prev;
        logic dat_prev;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.clk_prev = ps2_clk_i;
        e_d.dat_prev = ps2_dat_i;
        clk_fall_o   = e_q.clk_prev & ~ps2_clk_i;
        dat_fall_o   = e_q.dat_prev & ~ps2_dat_i;
        dat_edge_o   = e_q.dat_prev ^ ps2_dat_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '{clk_prev: 1'b1, dat_prev: 1'b1};
        end else begin
            e_q <= e_d;
        end
    end
endmodule

// File: rtl/ps2ts_stamp_store.sv
`timescale 1ns/1ps
module ps2ts_stamp_store #(
    parameter int TS_W  = 20,
    parameter int DEPTH = 12,
    parameter int SW    = TS_W + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            wr_i,
    input  logic [TS_W-1:0] wr_time_i,
    input  logic [SW-1:0]   thr_i,
    output logic            level_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][SW-1:0] slot;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t            s_d, s_q;
    logic [SW-1:0]     scaled;
    logic [DEPTH-1:0]  below;

    // Store 21*t so bit slots can be compared against odd multiples of
    // the frame duration without any division.
    always_comb begin
        scaled = (SW'(wr_time_i) << 4) + (SW'(wr_time_i) << 2) + SW'(wr_time_i);
    end

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (wr_i && (s_q.cnt < CW'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (s_q.cnt == CW'(i)) begin
                    s_d.slot[i] = scaled;
                end
            end
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    // A stored transition lies before the threshold when it falls inside
    // the bits decoded so far; the parity of such transitions is the level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign below[g] = (CW'(g) < s_q.cnt) && (s_q.slot[g] < thr_i);
    end

    assign level_o = ^below;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8: the entry count never passes the store depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R9: a clear request empties the store on the following cycle
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.cnt == '0));
endmodule

// File: rtl/ps2ts_frame_ctrl.sv
`timescale 1ns/1ps
module ps2ts_frame_ctrl
    import ps2ts_pkg::*;
#(
    parameter int TS_W        = 20,
    parameter int IDLE_CYCLES = 500000,
    parameter int SW          = TS_W + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_fall_i,
    input  logic            dat_fall_i,
    input  logic            dat_edge_i,
    input  logic            level_i,
    output logic            st_clr_o,
    output logic            st_wr_o,
    output logic [TS_W-1:0] st_time_o,
    output logic [SW-1:0]   thr_o,
    output logic [7:0]      rx_byte_o,
    output logic            rx_valid_o,
    output logic            parity_err_o,
    output logic            frame_err_o
);
    localparam int IW = $clog2(IDLE_CYCLES + 1);

    typedef struct packed {
        rx_state_e             st;
        logic [TS_W-1:0]       ts;
        logic [3:0]            ecnt;
        logic [IW-1:0]         idle;
        logic [SW-1:0]         thr;
        logic [SW-1:0]         step;
        logic [3:0]            bitn;
        logic [FRAME_BITS-1:0] frame;
        logic [7:0]            data;
        logic                  valid;
        logic                  perr;
        logic                  ferr;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        st_clr_o  = 1'b0;
        st_wr_o   = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (dat_fall_i) begin
                    c_d.st   = ST_RECV;
                    c_d.ts   = TS_W'(1);
                    c_d.ecnt = '0;
                    c_d.idle = '0;
                    st_clr_o = 1'b1;
                end
            end
            ST_RECV: begin
                if (c_q.ts != '1) begin
                    c_d.ts = c_q.ts + TS_W'(1);
                end
                c_d.idle = c_q.idle + IW'(1);
                st_wr_o  = dat_edge_i;
                if (clk_fall_i) begin
                    c_d.idle = '0;
                    if (c_q.ecnt == 4'(LAST_FALL)) begin
                        // Frame duration T = 10.5 bit periods; first slot edge at T.
                        c_d.thr  = SW'(c_q.ts);
                        c_d.step = SW'(c_q.ts) << 1;
                        c_d.bitn = '0;
                        c_d.st   = ST_DECODE;
                    end else begin
                        c_d.ecnt = c_q.ecnt + 4'd1;
                    end
                end else if (c_q.idle == IW'(IDLE_CYCLES - 1)) begin
                    c_d.st   = ST_IDLE;
                    st_clr_o = 1'b1;
                end
            end
            ST_DECODE: begin
                c_d.frame = {level_i, c_q.frame[FRAME_BITS-1:1]};
                c_d.thr   = c_q.thr + c_q.step;
                c_d.bitn  = c_q.bitn + 4'd1;
                if (c_q.bitn == 4'(LAST_FALL)) begin
                    c_d.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                c_d.data  = c_q.frame[8:1];
                c_d.ferr  = c_q.frame[0] | ~c_q.frame[FRAME_BITS-1];
                c_d.perr  = ~(^c_q.frame[9:1]);
                c_d.valid = 1'b1;
                c_d.st    = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign st_time_o    = c_q.ts;
    assign thr_o        = c_q.thr;
    assign rx_byte_o    = c_q.data;
    assign rx_valid_o   = c_q.valid;
    assign parity_err_o = c_q.perr;
    assign frame_err_o  = c_q.ferr;

    // R3: the strobe never lasts two cycles
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R4: results only move together with a strobe
    a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> ($stable(rx_byte_o) && $stable(parity_err_o) && $stable(frame_err_o)));

    // R2: the fall counter stays within one frame
    a_r2_fall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.ecnt <= 4'(LAST_FALL));

    // R2: timestamps never run backwards while a frame is open
    a_r2_ts_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RECV && $past(c_q.st) == ST_RECV) |-> (c_q.ts >= $past(c_q.ts)));
endmodule

// File: rtl/ps2_edge_rx.sv
`timescale 1ns/1ps
module ps2_edge_rx #(
    parameter int TS_W        = 20,
    parameter int STORE_DEPTH = 12,
    parameter int IDLE_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       parity_err_o,
    output logic       frame_err_o
);
    localparam int SW = TS_W + 5;

    logic            clk_fall, dat_fall, dat_edge;
    logic            st_clr, st_wr, level;
    logic [TS_W-1:0] st_time;
    logic [SW-1:0]   thr;

    ps2ts_line_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps2_clk_i  (ps2_clk_i),
        .ps2_dat_i  (ps2_dat_i),
        .clk_fall_o (clk_fall),
        .dat_fall_o (dat_fall),
        .dat_edge_o (dat_edge)
    );

    ps2ts_stamp_store #(
        .TS_W  (TS_W),
        .DEPTH (STORE_DEPTH),
        .SW    (SW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (st_clr),
        .wr_i      (st_wr),
        .wr_time_i (st_time),
        .thr_i     (thr),
        .level_o   (level)
    );

    ps2ts_frame_ctrl #(
        .TS_W        (TS_W),
        .IDLE_CYCLES (IDLE_CYCLES),
        .SW          (SW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_fall_i   (clk_fall),
        .dat_fall_i   (dat_fall),
        .dat_edge_i   (dat_edge),
        .level_i      (level),
        .st_clr_o     (st_clr),
        .st_wr_o      (st_wr),
        .st_time_o    (st_time),
        .thr_o        (thr),
        .rx_byte_o    (rx_byte_o),
        .rx_valid_o   (rx_valid_o),
        .parity_err_o (parity_err_o),
        .frame_err_o  (frame_err_o)
    );
endmodule

// File: tb/ps2_edge_rx_bench.sv
`timescale 1ns/1ps
module ps2_edge_rx_bench;
    localparam int TB_IDLE = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pclk = 1'b1;
    logic       pdat = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid, perr, ferr;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] last_byte = 8'h00;
    logic       last_perr = 1'b0;
    logic       last_ferr = 1'b0;

    always #2 clk = ~clk;

    ps2_edge_rx #(.TS_W(20), .STORE_DEPTH(12), .IDLE_CYCLES(TB_IDLE)) u_ps2_edge_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .ps2_clk_i    (pclk),
        .ps2_dat_i    (pdat),
        .rx_byte_o    (rx_byte),
        .rx_valid_o   (rx_valid),
        .parity_err_o (perr),
        .frame_err_o  (ferr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    function automatic logic exp_perr(input logic [7:0] d, input logic p);
        return ~(^{d, p});
    endfunction

    task automatic send_frame(input logic [7:0] d, input int bt, input int jit,
                              input bit bad_par, input bit bad_start,
                              input bit bad_stop, input string req);
        logic [10:0] bits;
        int off[11];
        int last;
        int b;
        int seen_valid;
        logic ex_perr, ex_ferr;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[1+i] = d[i];
        bits[9]  = odd_par(d) ^ bad_par;
        bits[10] = ~bad_stop;
        for (int k = 1; k < 11; k++) begin
            off[k] = (jit > 0) ? (int'($urandom_range(2*jit)) - jit) : 0;
        end
        off[0] = 0;
        last = 10*bt + bt/2;
        seen_valid = 0;
        for (int c = 0; c <= last; c++) begin
            @(negedge clk);
            if (rx_valid) seen_valid++;
            if (c == last) begin
                // R4: previous result still held while this frame is open
                check(rx_byte == last_byte && perr == last_perr && ferr == last_ferr,
                      "R4", "hold during reception", int'({perr, ferr, rx_byte}),
                      int'({last_perr, last_ferr, last_byte}));
            end
            pclk = ((c % bt) < bt/2) ? 1'b1 : 1'b0;
            b = 0;
            for (int k = 1; k < 11; k++) if (c >= k*bt + off[k]) b = k;
            pdat = bits[b];
            if (bad_start && b == 0 && c >= bt/4) pdat = 1'b1;
        end
        check(seen_valid == 0, "R3", "no strobe during reception", seen_valid, 0);
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(rx_valid == 1'b0, "R2", "strobe not yet due", int'(rx_valid), 0);
        @(posedge clk);
        @(negedge clk);
        ex_perr = exp_perr(d, bits[9]);
        ex_ferr = bad_start | bad_stop;
        check(rx_valid == 1'b1, "R2", "strobe on time", int'(rx_valid), 1);
        check(rx_byte == d, req, "byte", int'(rx_byte), int'(d));
        check(perr == ex_perr, "R5", "parity flag", int'(perr), int'(ex_perr));
        check(ferr == ex_ferr, "R6", "framing flag", int'(ferr), int'(ex_ferr));
        @(negedge clk);
        check(rx_valid == 1'b0, "R3", "strobe one cycle", int'(rx_valid), 0);
        last_byte = d;
        last_perr = ex_perr;
        last_ferr = ex_ferr;
        pclk = 1'b1;
        pdat = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rx_valid == 1'b0 && rx_byte == 8'h00 && perr == 1'b0 && ferr == 1'b0,
              "R1", "reset outputs", int'({rx_valid, perr, ferr, rx_byte}), 0);

        send_frame(8'h21, 40, 0, 0, 0, 0, "R2");
        send_frame(8'hAA, 60, 0, 0, 0, 0, "R8");
        send_frame(8'h55, 50, 0, 0, 0, 0, "R8");
        send_frame(8'h00, 30, 0, 0, 0, 0, "R2");
        send_frame(8'hFF, 44, 0, 0, 0, 0, "R2");
        send_frame(8'h3C, 20, 0, 0, 0, 0, "R7");
        send_frame(8'hC3, 100, 0, 0, 0, 0, "R7");
        send_frame(8'h5A, 48, 0, 1, 0, 0, "R5");
        send_frame(8'h81, 52, 0, 0, 1, 0, "R6");
        send_frame(8'h7E, 36, 0, 0, 0, 1, "R6");
        send_frame(8'hAA, 64, 0, 1, 0, 1, "R8");

        // R11: clock activity with data high and no frame open
        seen = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (rx_valid) seen++;
            pclk = ((c % 40) < 20) ? 1'b1 : 1'b0;
        end
        pclk = 1'b1;
        repeat (20) @(negedge clk);
        check(seen == 0 && !rx_valid, "R11", "no strobe from idle clocking", seen, 0);
        check(rx_byte == last_byte && perr == last_perr && ferr == last_ferr,
              "R11", "outputs unchanged", int'(rx_byte), int'(last_byte));

        // R9: partial frame then silence beyond the timeout window
        seen = 0;
        @(negedge clk);
        pdat = 1'b0;
        for (int c = 1; c < 5*40 + 20; c++) begin
            @(negedge clk);
            if (rx_valid) seen++;
            pclk = ((c % 40) < 20) ? 1'b1 : 1'b0;
            if (c == 40) pdat = 1'b1;
        end
        pclk = 1'b1;
        pdat = 1'b1;
        for (int c = 0; c < TB_IDLE + 60; c++) begin
            @(negedge clk);
            if (rx_valid) seen++;
        end
        check(seen == 0, "R9", "partial frame gave no strobe", seen, 0);
        send_frame(8'hB7, 40, 0, 0, 0, 0, "R9");

        // R10 and R7: random bytes, periods and boundary jitter
        for (int n = 0; n < 30; n++) begin
            int bt;
            logic [7:0] d;
            bit bp;
            bt = 2 * int'($urandom_range(50, 10));
            d  = 8'($urandom_range(255));
            bp = ($urandom_range(7) == 0);
            send_frame(d, bt, bt/4, bp, 0, 0, "R10");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule